// File: doc/BRIEF.md
# Grafcet Step-Transition Sequencer

This block is a synchronous sequence controller laid out the Grafcet way. Every step of a fixed chart owns one flip-flop, and every transition is a small gate that fires when all the steps above it are active and its own condition input is high. A firing transition clears the steps above it and sets the steps below it on the same rising clock edge. Because steps are individual bits rather than one encoded state, the chart can run two branches at once after a fork and wait for both before a join.

The chart has eight steps, numbered 0 to 7, and eight transitions. Each transition has one condition bit on the `cond` bus. Step 0 leads to step 1. Step 1 then chooses between step 2 and step 3, and the first choice has priority. Steps 2 and 3 merge into step 4. Step 4 forks into steps 5 and 6, which run in parallel. Steps 5 and 6 join into step 7, and step 7 loops back to step 0. Each action output mirrors its own step bit. The step vector is also brought out so that the active steps can be observed.

Top module: `grafcet_seq`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) loads `step_q` = 8'b0000_0001, that is step 0 alone. This holds whatever `cond` carries.
- R2: With step 0 active and cond[0] high, the edge clears step 0 and sets step 1.
- R3: A condition bit has no effect while any of its upstream steps is inactive, so `step_q` does not change.
- R4: With step 1 active, cond[1] moves the chart to step 2, and cond[2] alone moves it to step 3. If both are high, only step 2 is set and step 3 stays inactive.
- R5: Step 2 with cond[3], or step 3 with cond[4], clears that step and sets step 4.
- R6: With step 4 active and cond[5] high, one edge clears step 4 and sets both step 5 and step 6.
- R7: With steps 5 and 6 both active and cond[6] high, one edge clears both and sets step 7. While cond[6] is low, steps 5 and 6 both stay active.
- R8: With step 7 active and cond[7] high, the edge clears step 7 and sets step 0.
- R9: `act` equals `step_q` in every cycle, so an action shows in the same cycle that its step becomes active.
- R10: A step whose outgoing transitions are not enabled keeps its value across the edge.
- R11: After reset, either exactly one of steps 0 to 4 and 7 is active with steps 5 and 6 clear, or steps 5 and 6 are both active and no other step is active.
- R12: All transitions are evaluated from the step values held before the edge, so one edge advances each token by at most one transition, even when every condition is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| cond | input | 8 | One condition bit per transition; bit t belongs to transition t |
| act | output | 8 | Action lines, bit s is high while step s is active |
| step_q | output | 8 | Step register contents for observation |

## Verification
A condition presented before a rising edge is due in `step_q` right after that edge, because there is exactly one register between `cond` and the step vector. `act` is due in the same cycle as the step vector, because no register stands between them. The bench changes `cond` and `rst` 1 ns after a rising edge and samples both outputs 1 ns after the next rising edge. Every comparison is made against a result that is exactly one edge old. Reset is checked the same way, one edge after `rst` is raised.

// File: rtl/grafcet_seq_pkg.sv
package grafcet_seq_pkg;

  localparam int NUM_STEPS = 8;
  localparam int NUM_TRANS = 8;
  localparam int INIT_STEP = 0;

  typedef logic [NUM_STEPS-1:0] step_vec_t;
  typedef logic [NUM_TRANS-1:0] trans_vec_t;

  // step indices
  localparam int ST_START  = 0;
  localparam int ST_ARM    = 1;
  localparam int ST_PATH_A = 2;
  localparam int ST_PATH_B = 3;
  localparam int ST_MERGED = 4;
  localparam int ST_LANE_L = 5;
  localparam int ST_LANE_R = 6;
  localparam int ST_JOINED = 7;

  // transition indices (condition bit t belongs to transition t)
  localparam int TR_START = 0;
  localparam int TR_SEL_A = 1;
  localparam int TR_SEL_B = 2;
  localparam int TR_MRG_A = 3;
  localparam int TR_MRG_B = 4;
  localparam int TR_FORK  = 5;
  localparam int TR_JOIN  = 6;
  localparam int TR_LOOP  = 7;

  localparam step_vec_t INIT_VEC = step_vec_t'(1) << INIT_STEP;

  function automatic step_vec_t one_step(input int s);
    return step_vec_t'(1) << s;
  endfunction

  // steps that must all be active for transition t, and that it clears
  function automatic step_vec_t up_mask(input int t);
    case (t)
      TR_START: return one_step(ST_START);
      TR_SEL_A: return one_step(ST_ARM);
      TR_SEL_B: return one_step(ST_ARM);
      TR_MRG_A: return one_step(ST_PATH_A);
      TR_MRG_B: return one_step(ST_PATH_B);
      TR_FORK:  return one_step(ST_MERGED);
      TR_JOIN:  return one_step(ST_LANE_L) | one_step(ST_LANE_R);
      default:  return one_step(ST_JOINED);
    endcase
  endfunction

  // steps set by transition t
  function automatic step_vec_t dn_mask(input int t);
    case (t)
      TR_START: return one_step(ST_ARM);
      TR_SEL_A: return one_step(ST_PATH_A);
      TR_SEL_B: return one_step(ST_PATH_B);
      TR_MRG_A: return one_step(ST_MERGED);
      TR_MRG_B: return one_step(ST_MERGED);
      TR_FORK:  return one_step(ST_LANE_L) | one_step(ST_LANE_R);
      TR_JOIN:  return one_step(ST_JOINED);
      default:  return one_step(ST_START);
    endcase
  endfunction

  // transition that takes precedence over t, or -1 for none
  function automatic int yields_to(input int t);
    case (t)
      TR_SEL_B: return TR_SEL_A;
      TR_MRG_B: return TR_MRG_A;
      default:  return -1;
    endcase
  endfunction

endpackage

// File: rtl/grafcet_step_cell.sv
module grafcet_step_cell #(
  parameter bit INIT = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);

  // activation wins over deactivation, reset wins over both
  always_ff @(posedge clk) begin
    if (rst)        q_o <= INIT;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end

endmodule

// File: rtl/grafcet_fire_net.sv
module grafcet_fire_net
  import grafcet_seq_pkg::*;
(
  input  step_vec_t  step_i,
  input  trans_vec_t cond_i,
  output trans_vec_t fire_o
);

  trans_vec_t enabled;

  for (genvar t = 0; t < NUM_TRANS; t++) begin : g_tr
    localparam step_vec_t UP  = up_mask(t);
    localparam int        WIN = yields_to(t);

    assign enabled[t] = ((step_i & UP) == UP) && cond_i[t];

    if (WIN >= 0) begin : g_yield
      assign fire_o[t] = enabled[t] && !enabled[WIN];
    end else begin : g_free
      assign fire_o[t] = enabled[t];
    end
  end

endmodule

// File: rtl/grafcet_route.sv
module grafcet_route
  import grafcet_seq_pkg::*;
(
  input  trans_vec_t fire_i,
  output step_vec_t  set_o,
  output step_vec_t  clr_o
);

  always_comb begin
    set_o = '0;
    clr_o = '0;
    for (int t = 0; t < NUM_TRANS; t++) begin
      if (fire_i[t]) begin
        set_o = set_o | dn_mask(t);
        clr_o = clr_o | up_mask(t);
      end
    end
  end

endmodule

// File: rtl/grafcet_seq.sv
module grafcet_seq
  import grafcet_seq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_TRANS-1:0] cond,
  output logic [NUM_STEPS-1:0] act,
  output logic [NUM_STEPS-1:0] step_q
);

  trans_vec_t fire;
  step_vec_t  set_v;
  step_vec_t  clr_v;
  step_vec_t  state;

  grafcet_fire_net u_fire (
    .step_i (state),
    .cond_i (cond),
    .fire_o (fire)
  );

  grafcet_route u_route (
    .fire_i (fire),
    .set_o  (set_v),
    .clr_o  (clr_v)
  );

  for (genvar s = 0; s < NUM_STEPS; s++) begin : g_step
    grafcet_step_cell #(
      .INIT (INIT_VEC[s])
    ) u_cell (
      .clk   (clk),
      .rst   (rst),
      .set_i (set_v[s]),
      .clr_i (clr_v[s]),
      .q_o   (state[s])
    );
  end

  assign step_q = state;
  assign act    = state;

endmodule

// File: rtl/grafcet_seq_chk.sv
module grafcet_seq_chk
  import grafcet_seq_pkg::*;
(
  input logic                 clk,
  input logic                 rst,
  input logic [NUM_TRANS-1:0] cond,
  input logic [NUM_STEPS-1:0] step_q
);

  // R4
  sel_priority_chk: assert property (@(posedge clk) disable iff (rst)
    (step_q[ST_ARM] && cond[TR_SEL_A]) |=> (step_q[ST_PATH_A] && !step_q[ST_PATH_B] && !step_q[ST_ARM]));

  // R6
  fork_sets_both_chk: assert property (@(posedge clk) disable iff (rst)
    (step_q[ST_MERGED] && cond[TR_FORK]) |=> (step_q[ST_LANE_L] && step_q[ST_LANE_R] && !step_q[ST_MERGED]));

  // R7
  join_fires_chk: assert property (@(posedge clk) disable iff (rst)
    (step_q[ST_LANE_L] && step_q[ST_LANE_R] && cond[TR_JOIN]) |=> (step_q[ST_JOINED] && !step_q[ST_LANE_L] && !step_q[ST_LANE_R]));

  // R7
  join_waits_chk: assert property (@(posedge clk) disable iff (rst)
    (step_q[ST_LANE_L] && step_q[ST_LANE_R] && !cond[TR_JOIN]) |=> (step_q[ST_LANE_L] && step_q[ST_LANE_R]));

  // R11
  lanes_paired_chk: assert property (@(posedge clk) disable iff (rst)
    step_q[ST_LANE_L] == step_q[ST_LANE_R]);

  // R11
  single_token_chk: assert property (@(posedge clk) disable iff (rst)
    ($countones(step_q) == 1) || (step_q == (one_step(ST_LANE_L) | one_step(ST_LANE_R))));

  // R10
  start_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (step_q[ST_START] && !cond[TR_START]) |=> step_q[ST_START]);

endmodule

bind grafcet_seq grafcet_seq_chk u_chk (
  .clk    (clk),
  .rst    (rst),
  .cond   (cond),
  .step_q (step_q)
);

// File: tb/grafcet_seq_bench.sv
`timescale 1ns/1ps
module grafcet_seq_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] cond = 8'h00;
  logic [7:0] act;
  logic [7:0] step_q;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  grafcet_seq u_grafcet_seq (
    .clk    (clk),
    .rst    (rst),
    .cond   (cond),
    .act    (act),
    .step_q (step_q)
  );

  // apply cond, cross one rising edge, sample 1 ns later
  task automatic tick(input logic [7:0] c);
    cond = c;
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [7:0] actual, input logic [7:0] expected);
    checks++;
    if (actual !== expected) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, actual, expected);
    end
  endtask

  // next step vector derived from the requirements
  function automatic logic [7:0] model(input logic [7:0] s, input logic [7:0] c);
    logic [7:0] n = s;
    if (s[0] && c[0]) begin n[0] = 0; n[1] = 1; end
    if (s[1] && c[1])      begin n[1] = 0; n[2] = 1; end
    else if (s[1] && c[2]) begin n[1] = 0; n[3] = 1; end
    if (s[2] && c[3]) begin n[2] = 0; n[4] = 1; end
    if (s[3] && c[4]) begin n[3] = 0; n[4] = 1; end
    if (s[4] && c[5]) begin n[4] = 0; n[5] = 1; n[6] = 1; end
    if (s[5] && s[6] && c[6]) begin n[5] = 0; n[6] = 0; n[7] = 1; end
    if (s[7] && c[7]) begin n[7] = 0; n[0] = 1; end
    return n;
  endfunction

  task automatic do_reset();
    rst = 1'b1;
    tick(8'hFF);
    tick(8'hFF);
    chk("R1 reset", step_q, 8'b0000_0001);
    chk("R9 act", act, step_q);
    rst = 1'b0;
  endtask

  task automatic test_path_a();
    do_reset();
    tick(8'h00);       chk("R10 hold", step_q, 8'h01);
    tick(8'hFE);       chk("R3 foreign conds", step_q, 8'h01);
    tick(8'hFF);       chk("R12 one step per edge", step_q, 8'h02);
    chk("R2 start", step_q, 8'h02);
    chk("R9 act", act, 8'h02);
    tick(8'b0000_0110); chk("R4 both high picks first", step_q, 8'h04);
    tick(8'b0000_0100); chk("R10 path A holds", step_q, 8'h04);
    tick(8'b0000_1000); chk("R5 merge A", step_q, 8'h10);
    tick(8'b1100_0000); chk("R3 join cond w/o lanes", step_q, 8'h10);
    tick(8'b0010_0000); chk("R6 fork", step_q, 8'h60);
    chk("R9 act", act, 8'h60);
    tick(8'b1011_1111); chk("R7 join waits", step_q, 8'h60);
    tick(8'b0100_0000); chk("R7 join", step_q, 8'h80);
    tick(8'b0111_1111); chk("R10 step7 holds", step_q, 8'h80);
    tick(8'b1000_0000); chk("R8 loop", step_q, 8'h01);
  endtask

  task automatic test_path_b();
    do_reset();
    tick(8'h01);        chk("R2 start", step_q, 8'h02);
    tick(8'b0000_0100); chk("R4 second alone", step_q, 8'h08);
    tick(8'b0000_1000); chk("R3 wrong merge cond", step_q, 8'h08);
    tick(8'b0001_0000); chk("R5 merge B", step_q, 8'h10);
    tick(8'hFF);        chk("R12 fork only", step_q, 8'h60);
    rst = 1'b1;
    tick(8'hFF);        chk("R1 reset mid-run", step_q, 8'h01);
    rst = 1'b0;
  endtask

  task automatic test_random();
    logic [7:0] exp;
    do_reset();
    exp = 8'h01;
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] c = 8'($urandom) & 8'($urandom);
      exp = model(exp, c);
      tick(c);
      chk("R12 model", step_q, exp);
      chk("R9 act", act, step_q);
      chk("R11 lanes paired", {7'b0, step_q[5]}, {7'b0, step_q[6]});
      chk("R11 one token", 8'($countones(step_q & 8'b1001_1111) + int'(step_q[5])), 8'd1);
    end
  endtask

  initial begin
    test_path_a();
    test_path_b();
    test_random();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule